// File: doc/BRIEF.md
# Page Translation Buffer with Access Rights

The block holds a small, fully associative set of page translations and answers address lookups against it. Each lookup presents a virtual address, the kind of access being attempted (read, write or instruction fetch) and whether the requester runs in kernel or user mode. One cycle later the block returns either the translated physical address or a fault code. The fault code tells two cases apart: no translation exists for the page, or a translation exists but forbids the access.

Software-style maintenance commands change the table. An add command installs a translation with six access-right bits. A remove command deletes the translation for one virtual page. A flush command empties the table. Besides the eight writable slots there is one fixed translation, chosen by parameters, that no command can remove, so a minimal address range always stays reachable. Pages are 4 KiB and the page offset is copied unchanged into the physical address.

Top module: `xlat_tlb`

## Requirements
- R1: While reset is low and after it is released, no writable slot is valid, `rs_valid` is 0, `rs_paddr` is 0 and `rs_fault` is 0; only the fixed translation answers lookups.
- R2: Each cycle with `lk_valid` high yields exactly one cycle of `rs_valid` high on the next cycle, with no result in other cycles; a lookup sees the table as it was before any command issued in the same cycle.
- R3: A permitted lookup returns `rs_fault` 0 and `rs_paddr` equal to the stored physical page number followed by the low 12 bits of `lk_vaddr`.
- R4: A lookup whose virtual page (`lk_vaddr[31:12]`) matches no valid slot and not the fixed page returns `rs_fault` 1 and `rs_paddr` 0.
- R5: Access rights sit in flag bits 5..0 as kernel-execute, kernel-write, kernel-read, user-execute, user-write, user-read (bit 5 down to bit 0); bits above 5 are ignored. `lk_access` 0 is read, 1 write, 2 execute, 3 is always refused. Kernel mode consults bits 5..3, user mode bits 2..0; a refused access on a present page returns `rs_fault` 2 and `rs_paddr` 0.
- R6: `cmd_op` 1 (add) installs page `cmd_vaddr[31:12]` to `cmd_paddr[31:12]` with the flag bits; if that virtual page is already in a slot, that slot is overwritten so no page is ever held twice.
- R7: An add for a new page uses the lowest-numbered free slot; when all eight slots are valid it replaces the slot named by a round-robin pointer, which starts at slot 0, advances by one after each such replacement and returns to 0 on reset and flush.
- R8: `cmd_op` 2 (remove) invalidates the slot holding page `cmd_vaddr[31:12]`; a page not in any slot leaves the table unchanged, and the fixed translation is never affected.
- R9: `cmd_op` 3 (flush) invalidates all eight slots while the fixed translation stays usable; `cmd_op` 0 does nothing.
- R10: The fixed translation maps page `DEF_VPN` (default 0) to `DEF_PPN` (default 0) with rights `DEF_PERM` (default kernel read, write, execute only); a valid slot for the same page takes precedence over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_op | input | 2 | Maintenance command: 0 none, 1 add, 2 remove, 3 flush |
| cmd_vaddr | input | VA_W | Virtual address for add and remove |
| cmd_paddr | input | PA_W | Physical address for add |
| cmd_flags | input | FLAGS_W | Flags word for add; access rights in bits 5..0 |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_access | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_kernel | input | 1 | 1 for kernel mode, 0 for user mode |
| rs_valid | output | 1 | Lookup result valid |
| rs_paddr | output | PA_W | Translated physical address, 0 on a fault |
| rs_fault | output | 2 | 0 none, 1 page absent, 2 access refused |

## Verification
A corrupted slot, such as a stale valid bit or a wrong stored page number, shows up on the first later lookup of that page as a wrong address or a fault code flipping between 0, 1 and 2; a corrupted replacement pointer shows only after the table is full and a further new page evicts the wrong victim, so the bench fills the table, overflows it twice, punches a hole and refills, then probes every page touched. Rights decoding is probed with a flag pattern that grants one right per mode, across all four access codes and both modes.

// File: rtl/xlat_pkg.sv
// Shared encodings for the translation buffer: command codes, access
// kinds, fault codes and the positions of the access-right bits.
package xlat_pkg;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_ADD    = 2'd1,
        OP_REMOVE = 2'd2,
        OP_FLUSH  = 2'd3
    } xlat_op_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } xlat_acc_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_DENIED = 2'd2,
        FLT_UNUSED = 2'd3
    } xlat_fault_e;

    // Right bits: user group in the low three, kernel group above it.
    localparam int PERM_W    = 6;
    localparam int BIT_RD    = 0;
    localparam int BIT_WR    = 1;
    localparam int BIT_EX    = 2;
    localparam int KERN_BASE = 3;

endpackage

// File: rtl/xlat_entry_store.sv
// Slot storage of the translation buffer.
// Holds ENTRIES translations (valid, virtual page, physical page, rights)
// and applies one maintenance command per cycle. An add overwrites a slot
// already holding the page, else takes the lowest free slot, else the
// round-robin victim. Assumes cmd op encoding from xlat_pkg.
module xlat_entry_store
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [1:0]                       op,
    input  logic [VPN_W-1:0]                 op_vpn,
    input  logic [PPN_W-1:0]                 op_ppn,
    input  logic [PERM_W-1:0]                op_perm,
    output logic [ENTRIES-1:0]               ent_valid,
    output logic [ENTRIES-1:0][VPN_W-1:0]    ent_vpn,
    output logic [ENTRIES-1:0][PPN_W-1:0]    ent_ppn,
    output logic [ENTRIES-1:0][PERM_W-1:0]   ent_perm
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] op_hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   free_idx;
    logic               any_hit;
    logic               any_free;
    logic [IDX_W-1:0]   rr_ptr;
    logic [IDX_W-1:0]   tgt_idx;
    logic               use_rr;

    // Per-slot compare of the command page against stored pages.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmd_cmp
        assign op_hit[g] = ent_valid[g] && (ent_vpn[g] == op_vpn);
    end

    // Locate the matching slot and the lowest-numbered free slot.
    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (op_hit[i]) begin
                hit_idx = IDX_W'(i);
            end
            if (!ent_valid[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
        any_hit = |op_hit;
    end

    // Choose the slot an add writes: matching, else free, else victim.
    always_comb begin
        use_rr  = !any_hit && !any_free;
        tgt_idx = any_hit ? hit_idx : (any_free ? free_idx : rr_ptr);
    end

    // Apply the maintenance command to slot contents and victim pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_vpn   <= '0;
            ent_ppn   <= '0;
            ent_perm  <= '0;
            rr_ptr    <= '0;
        end else begin
            case (xlat_op_e'(op))
                OP_ADD: begin
                    ent_valid[tgt_idx] <= 1'b1;
                    ent_vpn[tgt_idx]   <= op_vpn;
                    ent_ppn[tgt_idx]   <= op_ppn;
                    ent_perm[tgt_idx]  <= op_perm;
                    if (use_rr) begin
                        rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
                    end
                end
                OP_REMOVE: begin
                    ent_valid <= ent_valid & ~op_hit;
                end
                OP_FLUSH: begin
                    ent_valid <= '0;
                    rr_ptr    <= '0;
                end
                default: begin
                end
            endcase
        end
    end

    // R6: a page is never held in two slots at once.
    a_r6_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_hit));

    // R9: after a flush no slot is valid.
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FLUSH) |=> (ent_valid == '0));

    // R8: the slot matched by a remove is invalid afterwards.
    a_r8_remove_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_REMOVE) |=> ((ent_valid & $past(op_hit)) == '0));

    // R7: the victim pointer only moves on an add or a flush.
    a_r7_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE || op == OP_REMOVE) |=> $stable(rr_ptr));

    // R6: an add leaves its page valid.
    a_r6_add_installs: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD) |=> (ent_valid[$past(tgt_idx)] && ent_vpn[$past(tgt_idx)] == $past(op_vpn)));

endmodule

// File: rtl/xlat_lookup_match.sv
// Lookup side of the translation buffer: compares the requested page with
// every slot and with the fixed translation, and returns the selected
// physical page and rights. Slots take precedence over the fixed entry.
// Assumes slots hold distinct pages (guaranteed by the store).
module xlat_lookup_match
    import xlat_pkg::*;
#(
    parameter int                 ENTRIES  = 8,
    parameter int                 VPN_W    = 20,
    parameter int                 PPN_W    = 20,
    parameter logic [VPN_W-1:0]   DEF_VPN  = '0,
    parameter logic [PPN_W-1:0]   DEF_PPN  = '0,
    parameter logic [PERM_W-1:0]  DEF_PERM = 6'b111000
) (
    input  logic [VPN_W-1:0]                 lk_vpn,
    input  logic [ENTRIES-1:0]               ent_valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0]    ent_vpn,
    input  logic [ENTRIES-1:0][PPN_W-1:0]    ent_ppn,
    input  logic [ENTRIES-1:0][PERM_W-1:0]   ent_perm,
    output logic                             found,
    output logic [PPN_W-1:0]                 sel_ppn,
    output logic [PERM_W-1:0]                sel_perm
);

    logic [ENTRIES-1:0] lk_hit;
    logic [PPN_W-1:0]   or_ppn;
    logic [PERM_W-1:0]  or_perm;
    logic               slot_hit;

    // Per-slot compare of the lookup page.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_lk_cmp
        assign lk_hit[g] = ent_valid[g] && (ent_vpn[g] == lk_vpn);
    end

    // AND-OR select of the single matching slot.
    always_comb begin
        or_ppn  = '0;
        or_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hit[i]) begin
                or_ppn  = or_ppn | ent_ppn[i];
                or_perm = or_perm | ent_perm[i];
            end
        end
        slot_hit = |lk_hit;
    end

    // Fall back on the fixed translation when no slot matches.
    always_comb begin
        found    = slot_hit || (lk_vpn == DEF_VPN);
        sel_ppn  = slot_hit ? or_ppn  : DEF_PPN;
        sel_perm = slot_hit ? or_perm : DEF_PERM;
    end

endmodule

// File: rtl/xlat_perm_check.sv
// Access-right decoder: picks the right bit for the requested access kind
// in the requester's mode. The reserved access kind is always refused.
module xlat_perm_check
    import xlat_pkg::*;
(
    input  logic [PERM_W-1:0] perm,
    input  logic [1:0]        access,
    input  logic              kernel,
    output logic              allow
);

    logic [2:0] group;

    // Select the kernel or user group of three rights.
    always_comb begin
        group = kernel ? perm[KERN_BASE +: 3] : perm[0 +: 3];
    end

    // Pick the bit for the access kind.
    always_comb begin
        case (xlat_acc_e'(access))
            ACC_READ:  allow = group[BIT_RD];
            ACC_WRITE: allow = group[BIT_WR];
            ACC_EXEC:  allow = group[BIT_EX];
            default:   allow = 1'b0;
        endcase
    end

endmodule

// File: rtl/xlat_tlb.sv
// Top of the page translation buffer. Maintenance commands change the
// slot store; lookups are matched combinationally against the store as it
// stands before this cycle's command, checked for rights, and the result
// is registered, so it appears one cycle after the request.
// Assumes PAGE_BITS of offset pass through and FLAGS_W > 6.
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int                                VA_W      = 32,
    parameter int                                PA_W      = 32,
    parameter int                                PAGE_BITS = 12,
    parameter int                                ENTRIES   = 8,
    parameter int                                FLAGS_W   = 32,
    parameter logic [VA_W-PAGE_BITS-1:0]         DEF_VPN   = '0,
    parameter logic [PA_W-PAGE_BITS-1:0]         DEF_PPN   = '0,
    parameter logic [5:0]                        DEF_PERM  = 6'b111000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cmd_op,
    input  logic [VA_W-1:0]    cmd_vaddr,
    input  logic [PA_W-1:0]    cmd_paddr,
    input  logic [FLAGS_W-1:0] cmd_flags,
    input  logic               lk_valid,
    input  logic [VA_W-1:0]    lk_vaddr,
    input  logic [1:0]         lk_access,
    input  logic               lk_kernel,
    output logic               rs_valid,
    output logic [PA_W-1:0]    rs_paddr,
    output logic [1:0]         rs_fault
);

    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PPN_W = PA_W - PAGE_BITS;

    logic [ENTRIES-1:0]              ent_valid;
    logic [ENTRIES-1:0][VPN_W-1:0]   ent_vpn;
    logic [ENTRIES-1:0][PPN_W-1:0]   ent_ppn;
    logic [ENTRIES-1:0][PERM_W-1:0]  ent_perm;
    logic                            found;
    logic [PPN_W-1:0]                sel_ppn;
    logic [PERM_W-1:0]               sel_perm;
    logic                            allow;
    logic                            unused_bits;

    assign unused_bits = ^{cmd_vaddr[PAGE_BITS-1:0], cmd_paddr[PAGE_BITS-1:0],
                           cmd_flags[FLAGS_W-1:PERM_W]};

    xlat_entry_store #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (cmd_op),
        .op_vpn    (cmd_vaddr[VA_W-1:PAGE_BITS]),
        .op_ppn    (cmd_paddr[PA_W-1:PAGE_BITS]),
        .op_perm   (cmd_flags[PERM_W-1:0]),
        .ent_valid (ent_valid),
        .ent_vpn   (ent_vpn),
        .ent_ppn   (ent_ppn),
        .ent_perm  (ent_perm)
    );

    xlat_lookup_match #(
        .ENTRIES  (ENTRIES),
        .VPN_W    (VPN_W),
        .PPN_W    (PPN_W),
        .DEF_VPN  (DEF_VPN),
        .DEF_PPN  (DEF_PPN),
        .DEF_PERM (DEF_PERM)
    ) match_i (
        .lk_vpn    (lk_vaddr[VA_W-1:PAGE_BITS]),
        .ent_valid (ent_valid),
        .ent_vpn   (ent_vpn),
        .ent_ppn   (ent_ppn),
        .ent_perm  (ent_perm),
        .found     (found),
        .sel_ppn   (sel_ppn),
        .sel_perm  (sel_perm)
    );

    xlat_perm_check perm_i (
        .perm   (sel_perm),
        .access (lk_access),
        .kernel (lk_kernel),
        .allow  (allow)
    );

    // Register the lookup outcome: address on success, zero plus code on fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid <= 1'b0;
            rs_paddr <= '0;
            rs_fault <= FLT_NONE;
        end else begin
            rs_valid <= lk_valid;
            if (lk_valid) begin
                if (!found) begin
                    rs_fault <= FLT_ABSENT;
                    rs_paddr <= '0;
                end else if (!allow) begin
                    rs_fault <= FLT_DENIED;
                    rs_paddr <= '0;
                end else begin
                    rs_fault <= FLT_NONE;
                    rs_paddr <= {sel_ppn, lk_vaddr[PAGE_BITS-1:0]};
                end
            end
        end
    end

    // R2: every request yields a result on the next cycle.
    a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);

    // R2: no result without a request.
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid);

    // R4: a faulting result carries a zero address.
    a_r4_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_fault != FLT_NONE) |-> (rs_paddr == '0));

    // R5: fault code 3 never appears.
    a_r5_fault_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> (rs_fault != FLT_UNUSED));

    // R3: the page offset passes through on success.
    a_r3_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rs_fault != FLT_NONE ||
                      rs_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0])));

    // R5: the reserved access kind is always refused.
    a_r5_rsvd_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_access == ACC_RSVD) |=> (rs_fault != FLT_NONE));

endmodule

// File: tb/xlat_tlb_tb_top.sv
// Scoreboard bench: driver tasks push expected results from a bench-side
// table model; a monitor pops and compares each registered result.
module xlat_tlb_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cmd_op;
    logic [31:0] cmd_vaddr;
    logic [31:0] cmd_paddr;
    logic [31:0] cmd_flags;
    logic        lk_valid;
    logic [31:0] lk_vaddr;
    logic [1:0]  lk_access;
    logic        lk_kernel;
    logic        rs_valid;
    logic [31:0] rs_paddr;
    logic [1:0]  rs_fault;

    always #5 clk = ~clk;

    xlat_tlb dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_op    (cmd_op),
        .cmd_vaddr (cmd_vaddr),
        .cmd_paddr (cmd_paddr),
        .cmd_flags (cmd_flags),
        .lk_valid  (lk_valid),
        .lk_vaddr  (lk_vaddr),
        .lk_access (lk_access),
        .lk_kernel (lk_kernel),
        .rs_valid  (rs_valid),
        .rs_paddr  (rs_paddr),
        .rs_fault  (rs_fault)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] q_addr[$];
    logic [1:0]  q_flt[$];
    string       q_tag[$];

    bit          m_valid[8];
    logic [19:0] m_vpn[8];
    logic [19:0] m_ppn[8];
    logic [5:0]  m_perm[8];
    int          m_rr;

    // Expected outcome of a lookup against the model table.
    function automatic void model_expect(input logic [31:0] va, input logic [1:0] acc,
                                         input logic k, output logic [31:0] pa,
                                         output logic [1:0] f);
        bit         hit = 1'b0;
        logic [19:0] ppn = '0;
        logic [5:0]  perm = '0;
        bit         ok;
        for (int i = 0; i < 8; i++) begin
            if (m_valid[i] && m_vpn[i] == va[31:12]) begin
                hit = 1'b1; ppn = m_ppn[i]; perm = m_perm[i];
            end
        end
        if (!hit && va[31:12] == 20'h0) begin
            hit = 1'b1; ppn = 20'h0; perm = 6'b111000;
        end
        if (!hit) begin
            f = 2'd1; pa = '0;
        end else begin
            ok = (acc == 2'd3) ? 1'b0 : perm[(k ? 3 : 0) + int'(acc)];
            if (ok) begin f = 2'd0; pa = {ppn, va[11:0]}; end
            else    begin f = 2'd2; pa = '0; end
        end
    endfunction

    // Model table update for one command.
    function automatic void model_apply(input logic [1:0] op, input logic [31:0] va,
                                        input logic [31:0] pa, input logic [31:0] fl);
        int slot = -1;
        if (op == 2'd1) begin
            for (int i = 0; i < 8; i++)
                if (m_valid[i] && m_vpn[i] == va[31:12]) slot = i;
            if (slot < 0)
                for (int i = 7; i >= 0; i--)
                    if (!m_valid[i]) slot = i;
            if (slot < 0) begin
                slot = m_rr;
                m_rr = (m_rr + 1) % 8;
            end
            m_valid[slot] = 1'b1;
            m_vpn[slot]   = va[31:12];
            m_ppn[slot]   = pa[31:12];
            m_perm[slot]  = fl[5:0];
        end else if (op == 2'd2) begin
            for (int i = 0; i < 8; i++)
                if (m_valid[i] && m_vpn[i] == va[31:12]) m_valid[i] = 1'b0;
        end else if (op == 2'd3) begin
            for (int i = 0; i < 8; i++) m_valid[i] = 1'b0;
            m_rr = 0;
        end
    endfunction

    task automatic do_cmd(input logic [1:0] op, input logic [31:0] va,
                          input logic [31:0] pa, input logic [31:0] fl);
        @(negedge clk);
        cmd_op = op; cmd_vaddr = va; cmd_paddr = pa; cmd_flags = fl;
        lk_valid = 1'b0;
        model_apply(op, va, pa, fl);
    endtask

    task automatic do_look(input logic [31:0] va, input logic [1:0] acc,
                           input logic k, input string tag);
        logic [31:0] pa;
        logic [1:0]  f;
        @(negedge clk);
        cmd_op = 2'd0;
        lk_valid = 1'b1; lk_vaddr = va; lk_access = acc; lk_kernel = k;
        model_expect(va, acc, k, pa, f);
        q_addr.push_back(pa); q_flt.push_back(f); q_tag.push_back(tag);
    endtask

    // Command and lookup in the same cycle: lookup sees the old table.
    task automatic do_both(input logic [1:0] op, input logic [31:0] va,
                           input logic [31:0] pa, input logic [31:0] fl,
                           input logic [31:0] lva, input logic [1:0] acc,
                           input logic k, input string tag);
        logic [31:0] epa;
        logic [1:0]  f;
        @(negedge clk);
        cmd_op = op; cmd_vaddr = va; cmd_paddr = pa; cmd_flags = fl;
        lk_valid = 1'b1; lk_vaddr = lva; lk_access = acc; lk_kernel = k;
        model_expect(lva, acc, k, epa, f);
        q_addr.push_back(epa); q_flt.push_back(f); q_tag.push_back(tag);
        model_apply(op, va, pa, fl);
    endtask

    task automatic do_idle();
        @(negedge clk);
        cmd_op = 2'd0; lk_valid = 1'b0;
    endtask

    // Monitor: compare each result against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && !done && rs_valid) begin
            checks++;
            if (q_addr.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected result paddr=%h fault=%0d expected none",
                         rs_paddr, rs_fault);
            end else begin
                logic [31:0] ea;
                logic [1:0]  ef;
                string       et;
                ea = q_addr.pop_front(); ef = q_flt.pop_front(); et = q_tag.pop_front();
                if (rs_paddr !== ea || rs_fault !== ef) begin
                    errors++;
                    $display("FAIL %s paddr=%h fault=%0d expected paddr=%h fault=%0d",
                             et, rs_paddr, rs_fault, ea, ef);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_op = 2'd0; cmd_vaddr = '0; cmd_paddr = '0; cmd_flags = '0;
        lk_valid = 1'b0; lk_vaddr = '0; lk_access = '0; lk_kernel = 1'b0;
        for (int i = 0; i < 8; i++) begin
            m_valid[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0; m_perm[i] = '0;
        end
        m_rr = 0;
        repeat (3) @(negedge clk);
        // R1: outputs idle in reset.
        checks++;
        if (rs_valid !== 1'b0 || rs_paddr !== '0 || rs_fault !== 2'd0) begin
            errors++;
            $display("FAIL R1 reset valid=%b paddr=%h fault=%0d expected 0 0 0",
                     rs_valid, rs_paddr, rs_fault);
        end
        rst_n = 1'b1;

        // R1 R10: after reset only the fixed page translates.
        do_look(32'h0000_0123, 2'd0, 1'b1, "R1 fixed kernel read");
        do_look(32'h0000_0456, 2'd0, 1'b0, "R10 fixed user read refused");
        do_look(32'h0000_0789, 2'd2, 1'b1, "R10 fixed kernel exec");
        do_look(32'h1234_5678, 2'd0, 1'b1, "R4 absent page");

        // R3: full rights translation.
        do_cmd(2'd1, 32'h1234_5000, 32'hABCD_E000, 32'h0000_003F);
        do_look(32'h1234_5678, 2'd2, 1'b1, "R3 kernel exec");
        do_look(32'h1234_5FFF, 2'd1, 1'b0, "R3 user write");
        do_look(32'h1234_5000, 2'd0, 1'b0, "R3 user read");

        // R5: kernel read + user write only, upper flag bits set.
        do_cmd(2'd1, 32'h2222_2000, 32'h3333_3000, 32'hFFFF_FFCA);
        for (int a = 0; a < 4; a++) begin
            do_look(32'h2222_2ABC, 2'(a), 1'b1, "R5 kernel rights");
            do_look(32'h2222_2ABC, 2'(a), 1'b0, "R5 user rights");
        end

        // R6: re-add of a present page overwrites it.
        do_cmd(2'd1, 32'h1234_5000, 32'h5555_5000, 32'h0000_0001);
        do_look(32'h1234_5678, 2'd0, 1'b0, "R6 overwritten user read");
        do_look(32'h1234_5678, 2'd0, 1'b1, "R6 overwritten kernel read");

        // R8: remove present, absent and fixed pages.
        do_cmd(2'd2, 32'h2222_2000, '0, '0);
        do_look(32'h2222_2ABC, 2'd0, 1'b1, "R8 removed page absent");
        do_cmd(2'd2, 32'h9999_9000, '0, '0);
        do_look(32'h1234_5678, 2'd0, 1'b0, "R8 unrelated page kept");
        do_cmd(2'd2, 32'h0000_0000, '0, '0);
        do_look(32'h0000_0AAA, 2'd1, 1'b1, "R8 fixed page kept");

        // R10: a slot for the fixed page takes precedence.
        do_cmd(2'd1, 32'h0000_0000, 32'h7777_7000, 32'h0000_0007);
        do_look(32'h0000_0010, 2'd0, 1'b0, "R10 slot overrides fixed");
        do_cmd(2'd2, 32'h0000_0000, '0, '0);
        do_look(32'h0000_0010, 2'd0, 1'b0, "R10 fixed restored");

        // R9: flush empties slots, fixed entry stays; idle op does nothing.
        do_cmd(2'd0, 32'h1234_5000, 32'h0, 32'h0);
        do_look(32'h1234_5678, 2'd0, 1'b0, "R9 idle op no effect");
        do_cmd(2'd3, '0, '0, '0);
        do_look(32'h1234_5678, 2'd0, 1'b0, "R9 flushed page absent");
        do_look(32'h0000_0010, 2'd0, 1'b1, "R9 fixed after flush");

        // R7: fill, overflow twice, hole, refill, overflow.
        for (int i = 0; i < 8; i++)
            do_cmd(2'd1, (32'h100 + 32'(i)) << 12, (32'h200 + 32'(i)) << 12, 32'h3F);
        do_cmd(2'd1, 32'h108 << 12, 32'h208 << 12, 32'h3F);
        do_cmd(2'd1, 32'h109 << 12, 32'h209 << 12, 32'h3F);
        for (int v = 32'h100; v <= 32'h10B; v++)
            do_look((32'(v) << 12) | 32'h0AB, 2'd0, 1'b1, "R7 after overflow");
        do_cmd(2'd2, 32'h104 << 12, '0, '0);
        do_cmd(2'd1, 32'h10A << 12, 32'h20A << 12, 32'h3F);
        do_cmd(2'd1, 32'h10B << 12, 32'h20B << 12, 32'h3F);
        for (int v = 32'h100; v <= 32'h10B; v++)
            do_look((32'(v) << 12) | 32'h0CD, 2'd0, 1'b1, "R7 after refill");

        // R7: flush resets the victim pointer.
        do_cmd(2'd3, '0, '0, '0);
        for (int i = 0; i < 9; i++)
            do_cmd(2'd1, (32'h300 + 32'(i)) << 12, (32'h400 + 32'(i)) << 12, 32'h3F);
        do_look(32'h300 << 12, 2'd0, 1'b1, "R7 pointer reset by flush");
        do_look(32'h301 << 12, 2'd0, 1'b1, "R7 pointer reset by flush");
        do_look(32'h308 << 12, 2'd0, 1'b1, "R7 pointer reset by flush");

        // R2: lookup in the same cycle as a flush sees the old table.
        do_both(2'd3, '0, '0, '0, 32'h0030_1111, 2'd0, 1'b1, "R2 same cycle flush");
        do_look(32'h0030_1111, 2'd0, 1'b1, "R2 after flush");

        do_idle();
        repeat (3) @(negedge clk);
        checks++;
        if (q_addr.size() != 0) begin
            errors++;
            $display("FAIL R2 missing results actual=%0d pending expected=0", q_addr.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule